// File: doc/BRIEF.md
# Any-Register SPI Access Sequencer

This block is a single-lane SPI master that reads or writes one byte in the internal register space of a serial NOR flash. It uses the flash's generic register-access commands. A host raises `start` for one cycle and supplies four things: the direction, a 32-bit register address, a write byte, and the number of dummy clocks that the device needs before register data appears. The block then runs the whole exchange on SCLK, CS_n and MOSI. It pulses `done` when the exchange is over and, after a read, presents the register byte on `rdata`.

Frames are kept to whole bytes on the wire. The dummy count is split into two parts: a whole-byte part, clocked before data, and a remainder of 0 to 7 bits. When the remainder is zero, one data byte is captured. When it is not zero, two bytes are captured. The register value is then rebuilt as `(first << rem) | (second >> (8 - rem))`. This works because the device keeps shifting out the same register contents for as long as SCLK runs.

A write always runs as two frames. The first is a stand-alone write-enable frame. After a chip-select gap comes the write frame. Volatile registers take the new value at the end of the frame, so no status polling follows.

The state machine has five states:
- `ST_IDLE`: waiting for a request.
- `ST_WEN`: write-enable frame.
- `ST_GAP`: chip-select high between the two frames of a write.
- `ST_XFER`: the register read or write frame.
- `ST_FINISH`: chip-select high before `done`.

Its transitions:
- IDLE to WEN on a write start, and IDLE to XFER on a read start.
- WEN to GAP on the last falling SCLK edge of the write-enable frame.
- GAP to XFER after the gap has elapsed.
- XFER to FINISH on the last falling edge of the frame.
- FINISH to IDLE after the trailing gap, with `done` pulsed.

Top module: `anyreg_spi_seq`

## Requirements
- R1: A read is one CS_n-low frame. It sends opcode 0x65, then the 4-byte address MSB first. It then clocks `8*floor(D/8)` dummy clocks, followed by 8 data clocks when `D mod 8 = 0`, or 16 when it is not. The frame is therefore 40 + 8*floor(D/8) + (8 or 16) SCLK periods long, with D in 0..31.
- R2: For every dummy count D, `rdata` after a read equals the byte the device repeats from its D-th rising edge after the address. This holds for remainders 1 to 7 through the two-byte rebuild.
- R3: A write is an 8-clock frame carrying opcode 0x06, followed by a separate 48-clock frame. The second frame carries opcode 0x71, the 4-byte address and the data byte, all MSB first.
- R4: CS_n stays high for at least 2 SCLK periods (4*CLK_DIV clock cycles) between the two frames of a write, and after the last frame before `done`.
- R5: The bus runs in SPI mode 0. SCLK is low whenever CS_n is high or changes. MOSI changes only when SCLK falls or when CS_n falls. MISO is sampled on rising SCLK edges.
- R6: `busy` is high from the cycle after an accepted `start` until the `done` cycle, and CS_n is high whenever `busy` is low. A `start` raised while busy is ignored: no extra frame is sent and the result of the running operation is unchanged.
- R7: `done` is a one-cycle pulse that ends each operation. `rdata` is updated only by reads and keeps its value across writes.
- R8: After reset, CS_n is 1 and SCLK, `busy`, `done` and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| op_wr | input | 1 | 1 = register write, 0 = register read |
| reg_addr | input | 32 | Register address, sent as 4 bytes |
| wdata | input | 8 | Byte to write |
| dummy | input | DUMMY_W | Dummy clocks the device needs before read data |
| rdata | output | 8 | Register byte from the last read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The bench sweeps every dummy count from 0 to 31 against a device model that repeats its register bits after exactly that many clocks. Each of the seven non-zero remainders therefore exercises the two-byte rebuild. A design that shifted the pair the wrong way, or captured only one byte, would return a rotated or truncated value for those counts. A design that miscounted the whole-byte part would show the wrong SCLK count per frame.

Writes are checked for the write-enable frame, the chip-select gap and the value the model stored. A missing write-enable frame leaves the model register unchanged, which the following read-back exposes. A short gap is reported by the gap timing check.

A `start` pulse injected in the middle of a read must not add a frame or corrupt the byte returned.

// File: rtl/anyreg_pkg.sv
package anyreg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WEN,
        ST_GAP,
        ST_XFER,
        ST_FINISH
    } seq_state_e;

    localparam logic [7:0] OPC_REG_RD = 8'h65;
    localparam logic [7:0] OPC_REG_WR = 8'h71;
    localparam logic [7:0] OPC_WEN    = 8'h06;
endpackage

// File: rtl/anyreg_tick.sv
// Half-period strobe for SCLK: one pulse every DIV clocks while enabled.
module anyreg_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/anyreg_merge.sv
// Rebuilds the register byte from the last captured bits and the
// sub-byte part of the dummy count.
module anyreg_merge (
    input  logic [15:0] pair,
    input  logic [2:0]  rem,
    output logic [7:0]  value
);
    logic [15:0] shifted;

    always_comb begin
        shifted = pair << rem;
        if (rem == 3'd0) begin
            value = pair[7:0];
        end else begin
            value = shifted[15:8];
        end
    end
endmodule

// File: rtl/anyreg_spi_seq.sv
module anyreg_spi_seq #(
    parameter int CLK_DIV  = 2,
    parameter int DUMMY_W  = 5,
    parameter int GAP_SCLK = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               op_wr,
    input  logic [31:0]        reg_addr,
    input  logic [7:0]         wdata,
    input  logic [DUMMY_W-1:0] dummy,
    output logic [7:0]         rdata,
    output logic               done,
    output logic               busy,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    input  logic               miso
);
    import anyreg_pkg::*;

    localparam int ADDR_W    = 32;
    localparam int HDR_BITS  = 8 + ADDR_W;
    localparam int TX_W      = HDR_BITS + 8;
    localparam int MAX_BITS  = HDR_BITS + (1 << DUMMY_W) + 16;
    localparam int CNT_W     = $clog2(MAX_BITS + 1);
    localparam int GAP_TICKS = 2 * GAP_SCLK;
    localparam int GW        = $clog2(GAP_TICKS + 1);

    seq_state_e state, state_nx;

    logic               tick;
    logic               wr_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [7:0]         wdata_q;
    logic [DUMMY_W-1:0] dummy_q;
    logic [TX_W-1:0]    txsr;
    logic [15:0]        rxsr;
    logic [CNT_W-1:0]   bitcnt;
    logic [CNT_W-1:0]   nbits;
    logic [CNT_W-1:0]   rd_bits;
    logic [GW-1:0]      gcnt;
    logic               sclk_q;
    logic               cs_q;
    logic [7:0]         rdata_q;
    logic               done_q;
    logic [7:0]         merged;
    logic               in_frame;
    logic               last_fall;
    logic               gap_last;

    anyreg_tick #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state != ST_IDLE),
        .tick  (tick)
    );

    anyreg_merge u_merge (
        .pair  (rxsr),
        .rem   (dummy_q[2:0]),
        .value (merged)
    );

    // Frame length of a read: header, whole dummy bytes, one or two data bytes.
    always_comb begin
        rd_bits = CNT_W'(HDR_BITS) + (CNT_W'(dummy) & ~CNT_W'(7))
                + ((dummy[2:0] != 3'd0) ? CNT_W'(16) : CNT_W'(8));
    end

    assign in_frame  = (state == ST_WEN) || (state == ST_XFER);
    assign last_fall = in_frame && tick && sclk_q && (bitcnt == nbits - 1'b1);
    assign gap_last  = tick && (gcnt == GW'(GAP_TICKS - 1));

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = op_wr ? ST_WEN : ST_XFER;
            ST_WEN:    if (last_fall) state_nx = ST_GAP;
            ST_GAP:    if (gap_last) state_nx = ST_XFER;
            ST_XFER:   if (last_fall) state_nx = ST_FINISH;
            ST_FINISH: if (gap_last) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            dummy_q <= '0;
            txsr    <= '0;
            rxsr    <= '0;
            bitcnt  <= '0;
            nbits   <= '0;
            gcnt    <= '0;
            sclk_q  <= 1'b0;
            cs_q    <= 1'b1;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        wr_q    <= op_wr;
                        addr_q  <= reg_addr;
                        wdata_q <= wdata;
                        dummy_q <= dummy;
                        cs_q    <= 1'b0;
                        sclk_q  <= 1'b0;
                        bitcnt  <= '0;
                        gcnt    <= '0;
                        if (op_wr) begin
                            txsr  <= {OPC_WEN, {(TX_W-8){1'b0}}};
                            nbits <= CNT_W'(8);
                        end else begin
                            txsr  <= {OPC_REG_RD, reg_addr, 8'h00};
                            nbits <= rd_bits;
                        end
                    end
                end
                ST_WEN, ST_XFER: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            rxsr   <= {rxsr[14:0], miso};
                        end else begin
                            sclk_q <= 1'b0;
                            txsr   <= txsr << 1;
                            bitcnt <= bitcnt + 1'b1;
                            if (last_fall) begin
                                cs_q   <= 1'b1;
                                bitcnt <= '0;
                                gcnt   <= '0;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        gcnt <= gcnt + 1'b1;
                        if (gap_last) begin
                            gcnt  <= '0;
                            cs_q  <= 1'b0;
                            txsr  <= {OPC_REG_WR, addr_q, wdata_q};
                            nbits <= CNT_W'(TX_W);
                        end
                    end
                end
                ST_FINISH: begin
                    if (tick) begin
                        gcnt <= gcnt + 1'b1;
                        if (gap_last) begin
                            gcnt   <= '0;
                            done_q <= 1'b1;
                            if (!wr_q) rdata_q <= merged;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy  = (state != ST_IDLE);
    assign done  = done_q;
    assign rdata = rdata_q;
    assign sclk  = sclk_q;
    assign cs_n  = cs_q;
    assign mosi  = txsr[TX_W-1];
endmodule

// File: rtl/anyreg_spi_seq_chk.sv
module anyreg_spi_seq_chk #(
    parameter int CLK_DIV  = 2,
    parameter int GAP_SCLK = 2
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic sclk,
    input logic cs_n,
    input logic mosi
);
    localparam int MIN_HI = 2 * GAP_SCLK * CLK_DIV;

    logic [15:0] hi_cnt;
    logic        had_frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt    <= '0;
            had_frame <= 1'b0;
        end else begin
            if (!cs_n) hi_cnt <= '0;
            else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
            if (!busy) had_frame <= 1'b0;
            else if (!cs_n) had_frame <= 1'b1;
        end
    end

    // R5
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R5
    mosi_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$fell(sclk)) |-> $stable(mosi));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R6
    cs_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    // R4
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && had_frame) |-> (hi_cnt >= 16'(MIN_HI)));

    // R4
    tail_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hi_cnt >= 16'(MIN_HI)));
endmodule

bind anyreg_spi_seq anyreg_spi_seq_chk #(
    .CLK_DIV  (CLK_DIV),
    .GAP_SCLK (GAP_SCLK)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .done  (done),
    .sclk  (sclk),
    .cs_n  (cs_n),
    .mosi  (mosi)
);

// File: tb/test_anyreg_spi_seq.sv
`timescale 1ns/1ps
module test_anyreg_spi_seq;
    localparam int CLK_DIV  = 2;
    localparam int DUMMY_W  = 5;
    localparam int GAP_SCLK = 2;
    localparam int MIN_HI_NS = 2 * GAP_SCLK * CLK_DIV * 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic op_wr = 1'b0;
    logic [31:0] reg_addr = '0;
    logic [7:0] wdata = '0;
    logic [DUMMY_W-1:0] dummy = '0;
    logic [7:0] rdata;
    logic done, busy, sclk, cs_n, mosi;
    logic miso = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    anyreg_spi_seq #(.CLK_DIV(CLK_DIV), .DUMMY_W(DUMMY_W), .GAP_SCLK(GAP_SCLK)) i_anyreg_spi_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_wr(op_wr), .reg_addr(reg_addr),
        .wdata(wdata), .dummy(dummy), .rdata(rdata), .done(done), .busy(busy),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

    // ---------------- device model ----------------
    logic [7:0]  regs [16];
    int          cur_lat = 0;
    int          rise_n = 0;
    logic [7:0]  op_m;
    logic [31:0] addr_m;
    logic [7:0]  wd_m;
    bit          in_frame = 1'b0;
    bit          wel = 1'b0;
    int          frames = 0;
    logic [7:0]  last_op, prev_op;
    int          last_bits = 0, prev_bits = 0;
    logic [31:0] last_addr;
    realtime     t_rise = 0.0;
    int          gap_err = 0;
    int          mode_err = 0;

    always @(negedge cs_n) begin
        if (sclk !== 1'b0) mode_err++;
        if (frames > 0 && busy && ($realtime - t_rise) < MIN_HI_NS) gap_err++;
        in_frame = 1'b1;
        rise_n = 0;
        miso = 1'b0;
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            if (rise_n < 8) op_m = {op_m[6:0], mosi};
            else if (rise_n < 40) addr_m = {addr_m[30:0], mosi};
            else if (rise_n < 48) wd_m = {wd_m[6:0], mosi};
            rise_n++;
        end
    end

    always @(negedge sclk) begin
        if (!cs_n && op_m == 8'h65 && rise_n >= 8) begin
            int idx;
            idx = rise_n - 40 - cur_lat;
            if (idx >= 0) miso = regs[addr_m[3:0]][7 - (idx % 8)];
            else miso = 1'b0;
        end
    end

    always @(posedge cs_n) begin
        if (in_frame) begin
            if (sclk !== 1'b0) mode_err++;
            in_frame = 1'b0;
            t_rise = $realtime;
            frames++;
            prev_op = last_op; prev_bits = last_bits;
            last_op = op_m; last_bits = rise_n; last_addr = addr_m;
            if (op_m == 8'h06 && rise_n == 8) wel = 1'b1;
            if (op_m == 8'h71) begin
                if (wel && rise_n == 48) regs[addr_m[3:0]] = wd_m;
                wel = 1'b0;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int rd_len(input int d);
        return 40 + (d & ~7) + (((d % 8) != 0) ? 16 : 8);
    endfunction

    int busy_err;
    int done_len;
    realtime done_t;

    // Runs one operation; optionally pulses start again mid-operation.
    task automatic run_op(input bit wr, input logic [31:0] a, input logic [7:0] wd,
                          input int d, input bit poke);
        int cyc;
        cur_lat = d;
        @(negedge clk);
        start = 1'b1; op_wr = wr; reg_addr = a; wdata = wd; dummy = DUMMY_W'(d);
        @(negedge clk);
        start = 1'b0;
        op_wr = ~wr; reg_addr = ~a; wdata = ~wd; dummy = '1;
        busy_err = 0;
        cyc = 0;
        while (done !== 1'b1 && cyc < 5000) begin
            if (busy !== 1'b1) busy_err++;
            if (poke && cyc == 30) start = 1'b1;
            if (poke && cyc == 31) start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        done_t = $realtime;
        if (busy !== 1'b0) busy_err++;
        @(negedge clk);
        done_len = (done === 1'b1) ? 2 : 1;
        repeat (3) @(negedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 8'h3C ^ 8'(i * 37);
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(cs_n === 1'b1, "R8 cs_n", 32'(cs_n), 1);
        chk(sclk === 1'b0 && busy === 1'b0 && done === 1'b0, "R8 sclk/busy/done",
            {29'd0, sclk, busy, done}, 0);
        chk(rdata === 8'h00, "R8 rdata", 32'(rdata), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Read sweep over every dummy count (R1, R2)
        for (int d = 0; d < 32; d++) begin
            logic [31:0] a;
            logic [7:0]  e;
            int f0;
            a = 32'h0080_0000 + 32'(d % 16) + (32'(d) << 8);
            e = regs[a[3:0]];
            f0 = frames;
            run_op(1'b0, a, 8'h00, d, 1'b0);
            chk(rdata === e, $sformatf("R2 read d=%0d", d), 32'(rdata), 32'(e));
            chk(last_bits == rd_len(d), $sformatf("R1 frame length d=%0d", d), last_bits, rd_len(d));
            chk(last_op == 8'h65 && last_addr == a && frames == f0 + 1,
                $sformatf("R1 opcode/addr d=%0d", d), last_addr, a);
            chk(busy_err == 0, "R6 busy during op", busy_err, 0);
            chk(done_len == 1, "R7 done one cycle", done_len, 1);
            chk(($realtime - 0.0) >= 0.0 && (done_t - t_rise) >= MIN_HI_NS, "R4 tail gap",
                32'(int'(done_t - t_rise)), MIN_HI_NS);
        end

        // Writes, then read back (R3, R7)
        for (int k = 0; k < 6; k++) begin
            logic [31:0] a;
            logic [7:0]  v, rd_before;
            int f0;
            a = 32'h0080_0002 + 32'(k * 3);
            v = 8'hA5 ^ 8'(k * 29);
            rd_before = rdata;
            f0 = frames;
            run_op(1'b1, a, v, 0, 1'b0);
            chk(frames == f0 + 2, "R3 two frames", frames - f0, 2);
            chk(prev_op == 8'h06 && prev_bits == 8, "R3 write-enable frame", {prev_op, 24'(prev_bits)}, {8'h06, 24'd8});
            chk(last_op == 8'h71 && last_bits == 48 && last_addr == a, "R3 write frame",
                {last_op, 24'(last_bits)}, {8'h71, 24'd48});
            chk(regs[a[3:0]] === v, "R3 value stored", 32'(regs[a[3:0]]), 32'(v));
            chk(rdata === rd_before, "R7 rdata held on write", 32'(rdata), 32'(rd_before));
            chk(busy_err == 0, "R6 busy during write", busy_err, 0);
            run_op(1'b0, a, 8'h00, 9 + k, 1'b0);
            chk(rdata === v, "R2 read back after write", 32'(rdata), 32'(v));
        end

        // Start while busy is ignored (R6)
        begin
            logic [7:0] e;
            int f0;
            e = regs[4'h7];
            f0 = frames;
            run_op(1'b0, 32'h0080_0007, 8'h00, 13, 1'b1);
            chk(frames == f0 + 1, "R6 no extra frame", frames - f0, 1);
            chk(rdata === e, "R6 result unaffected", 32'(rdata), 32'(e));
            repeat (20) @(negedge clk);
            chk(busy === 1'b0 && cs_n === 1'b1, "R6 idle after ignored start", {30'd0, busy, cs_n}, 1);
        end

        chk(gap_err == 0, "R4 CS_n gap between frames", gap_err, 0);
        chk(mode_err == 0, "R5 SCLK low at CS_n edges", mode_err, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule